// File: doc/BRIEF.md
# Fifth-Order Single-Bit Noise Shaper

This block turns a stream of signed multi-bit samples, one per channel, into a 1-bit stream per channel. It runs at the oversampled rate, 64 times the audio rate. A rate-enable input marks the clock cycles that carry a new oversampled sample. Each channel closes a delta-sigma loop around a chain of five integrators. Every integrator receives the fed-back output value scaled by a power of two, so each coefficient is an arithmetic shift. The loop pushes quantisation noise out of the audio band towards high frequencies, and the 1-bit result drives the reconstruction stage that follows.

Before a sample enters the loop it is clamped to half of full scale, which keeps the high-order loop in its stable region. Every integrator sum is tested against the limits of its register. If any sum in a channel reaches a limit, all five states of that channel are cleared in the same update, and a one-cycle overload pulse is raised.

Top module: `ns5_shaper`

## Requirements
- R1: While reset is asserted and directly after it, all integrator states are zero, every `bit_o` is 1 and every `ovl_o` is 0.
- R2: State and outputs change only on clock edges where `step_en` is 1. On any other edge `bit_o` keeps its value and `ovl_o` is 0.
- R3: The sample is clamped to the range [-2^(IN_W-2), +2^(IN_W-2)] before it enters the loop, so any input beyond that range acts exactly like the nearest bound.
- R4: The feedback value is fixed by the present output bit: a bit of 1 gives +2^(IN_W-1) and a bit of 0 gives -2^(IN_W-1).
- R5: The first integrator adds (u - v) >>> K1, where u is the clamped sample, v is the feedback value and >>> is an arithmetic (flooring) right shift.
- R6: Integrator k, for k from 2 to 5, adds x(k-1) - (v >>> Kk). All terms use the values from before the update.
- R7: If any updated sum of a channel is at or above 2^(ACC_W-1)-1, or at or below -2^(ACC_W-1), then all five states of that channel become zero in that update.
- R8: `ovl_o[c]` is 1 for exactly the cycle after an update of channel c that cleared its states. In that cycle `bit_o[c]` is 1.
- R9: Channels share no state. The sample slice `smp_i[c*IN_W +: IN_W]` affects only channel c.
- R10: `bit_o[c]` is 1 when the fifth integrator state, as registered after the update, is non-negative, and 0 when it is negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampled-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Rate enable; 1 marks a cycle that updates the loop |
| smp_i | input | NUM_CH*IN_W | Signed samples, channel c in bits c*IN_W +: IN_W |
| bit_o | output | NUM_CH | 1-bit shaped output per channel |
| ovl_o | output | NUM_CH | One-cycle pulse after a state clear, per channel |

## Verification
The bench builds two copies of the block. The first has two channels, IN_W=12, ACC_W=20 and shifts 10,7,4,2,1. At these widths a reference model written from R3 to R10 follows the output bit for bit, across clamped, unclamped and gated input sequences. The second has one channel, ACC_W equal to IN_W, and every shift set to zero, which drives the integrators into their limits on the very first update. That makes the clear and the overload pulse certain to occur, so they can be observed directly rather than waited for.

// File: rtl/ns5_pkg.sv
package ns5_pkg;
   // number of integrators in the loop filter
   localparam int LOOP_ORDER = 5;
   // guard bits above the state width for unclamped sums
   localparam int GUARD_W = 2;
endpackage

// File: rtl/ns5_limit.sv
module ns5_limit #(
   parameter int IN_W = 16
) (
   input  logic signed [IN_W-1:0] raw_i,
   output logic signed [IN_W-1:0] lim_o
);
   // half of full scale, both polarities
   localparam logic signed [IN_W-1:0] HI = IN_W'(2 ** (IN_W - 2));
   localparam logic signed [IN_W-1:0] LO = -HI;

   always_comb begin
      if (raw_i > HI)
         lim_o = HI;
      else if (raw_i < LO)
         lim_o = LO;
      else
         lim_o = raw_i;
   end
endmodule

// File: rtl/ns5_integ.sv
module ns5_integ #(
   parameter int ACC_W = 24,
   parameter int EXT_W = 26
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step_i,
   input  logic                    clear_i,
   input  logic signed [EXT_W-1:0] delta_i,
   output logic signed [ACC_W-1:0] state_o,
   output logic                    hit_o
);
   localparam logic signed [EXT_W-1:0] TOP = (EXT_W'(1) <<< (ACC_W - 1)) - EXT_W'(1);
   localparam logic signed [EXT_W-1:0] BOT = -(EXT_W'(1) <<< (ACC_W - 1));

   logic signed [ACC_W-1:0] state_q;
   logic signed [EXT_W-1:0] sum;

   assign sum     = $signed({{(EXT_W-ACC_W){state_q[ACC_W-1]}}, state_q}) + delta_i;
   assign hit_o   = (sum >= TOP) || (sum <= BOT);
   assign state_o = state_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= '0;
      else if (step_i)
         state_q <= clear_i ? '0 : sum[ACC_W-1:0];
   end
endmodule

// File: rtl/ns5_chan.sv
module ns5_chan
   import ns5_pkg::*;
#(
   parameter int IN_W  = 16,
   parameter int ACC_W = 24,
   parameter int FB_SHIFT [LOOP_ORDER] = '{10, 7, 4, 2, 1}
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   step_i,
   input  logic signed [IN_W-1:0] samp_i,
   output logic                   bit_o,
   output logic                   ovl_o
);
   localparam int EXT_W = ACC_W + GUARD_W;
   localparam logic signed [EXT_W-1:0] FB_POS = EXT_W'(1) <<< (IN_W - 1);
   localparam logic signed [EXT_W-1:0] FB_NEG = -FB_POS;

   logic signed [IN_W-1:0]  u_lim;
   logic signed [EXT_W-1:0] u_ext;
   logic signed [EXT_W-1:0] fb;
   logic signed [EXT_W-1:0] delta [LOOP_ORDER];
   logic signed [ACC_W-1:0] st    [LOOP_ORDER];
   logic [LOOP_ORDER-1:0]   hit;
   logic                    any_hit;
   logic                    qbit;
   logic                    ovl_q;

   ns5_limit #(.IN_W(IN_W)) u_limit (
      .raw_i (samp_i),
      .lim_o (u_lim)
   );

   assign u_ext   = $signed({{(EXT_W-IN_W){u_lim[IN_W-1]}}, u_lim});
   assign qbit    = ~st[LOOP_ORDER-1][ACC_W-1];
   assign fb      = qbit ? FB_POS : FB_NEG;
   assign any_hit = |hit;

   for (genvar k = 0; k < LOOP_ORDER; k++) begin : g_stage
      if (k == 0) begin : g_head
         assign delta[k] = (u_ext - fb) >>> FB_SHIFT[k];
      end else begin : g_tail
         assign delta[k] = $signed({{(EXT_W-ACC_W){st[k-1][ACC_W-1]}}, st[k-1]})
                           - (fb >>> FB_SHIFT[k]);
      end

      ns5_integ #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_integ (
         .clk     (clk),
         .rst_n   (rst_n),
         .step_i  (step_i),
         .clear_i (any_hit),
         .delta_i (delta[k]),
         .state_o (st[k]),
         .hit_o   (hit[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovl_q <= 1'b0;
      else
         ovl_q <= step_i & any_hit;
   end

   assign bit_o = qbit;
   assign ovl_o = ovl_q;
endmodule

// File: rtl/ns5_shaper.sv
module ns5_shaper
   import ns5_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int IN_W   = 16,
   parameter int ACC_W  = 24,
   parameter int FB_SHIFT [LOOP_ORDER] = '{10, 7, 4, 2, 1}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step_en,
   input  logic [NUM_CH*IN_W-1:0]   smp_i,
   output logic [NUM_CH-1:0]        bit_o,
   output logic [NUM_CH-1:0]        ovl_o
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("ns5_shaper: NUM_CH must be at least 1");
   end
   if (IN_W < 4) begin : g_bad_in
      $error("ns5_shaper: IN_W must be at least 4");
   end
   if (ACC_W < IN_W) begin : g_bad_acc
      $error("ns5_shaper: ACC_W must not be below IN_W");
   end
   for (genvar g = 0; g < LOOP_ORDER; g++) begin : g_shift_chk
      if (FB_SHIFT[g] < 0 || FB_SHIFT[g] > IN_W - 1) begin : g_bad_shift
         $error("ns5_shaper: feedback shift out of range");
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ns5_chan #(
         .IN_W     (IN_W),
         .ACC_W    (ACC_W),
         .FB_SHIFT (FB_SHIFT)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .step_i (step_en),
         .samp_i (smp_i[c*IN_W +: IN_W]),
         .bit_o  (bit_o[c]),
         .ovl_o  (ovl_o[c])
      );
   end
endmodule

// File: rtl/ns5_shaper_chk.sv
module ns5_shaper_chk #(
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_en,
   input logic [NUM_CH-1:0] bit_o,
   input logic [NUM_CH-1:0] ovl_o
);
   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((bit_o == '1) && (ovl_o == '0)));

   // R2
   hold_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(bit_o));

   // R2
   quiet_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> (ovl_o == '0));

   // R8
   clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ovl_o & ~bit_o) == '0));

   // R8
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ovl_o) |-> $past(step_en));
endmodule

bind ns5_shaper ns5_shaper_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .step_en (step_en),
   .bit_o   (bit_o),
   .ovl_o   (ovl_o)
);

// File: tb/ns5_shaper_tb.sv
module ns5_shaper_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 2;
   localparam int INW   = 12;
   localparam int ACCW  = 20;
   localparam int SH [5] = '{10, 7, 4, 2, 1};
   localparam int ZSH [5] = '{0, 0, 0, 0, 0};
   localparam longint FBV  = 64'sd1 <<< (INW - 1);
   localparam longint LIMV = 64'sd1 <<< (INW - 2);
   localparam longint MAXV = (64'sd1 <<< (ACCW - 1)) - 1;
   localparam longint MINV = -(64'sd1 <<< (ACCW - 1));
   localparam int NVEC = 16;
   localparam bit VEC_EN [NVEC] = '{1,1,1,0,1,1,0,0,1,1,1,1,0,1,1,1};
   localparam int VEC_A  [NVEC] = '{0, 2047, -2048, 500, 1024, -1025, 0, 77,
                                    300, -700, 1500, -1500, 9, 1023, -1024, 12};
   localparam int VEC_B  [NVEC] = '{0, -2048, 2047, -3, 333, 1025, 5, 6,
                                    -300, 700, 0, 2000, 11, -2000, 1, -12};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic step_en = 1'b0;
   logic [NCH*INW-1:0] smp = '0;
   logic [NCH-1:0] bit_o;
   logic [NCH-1:0] ovl_o;

   logic step_z = 1'b0;
   logic [INW-1:0] smp_z = '0;
   logic [0:0] bit_z;
   logic [0:0] ovl_z;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   longint mx [NCH][5];

   always #(CLK_PERIOD/2) clk = ~clk;

   ns5_shaper #(.NUM_CH(NCH), .IN_W(INW), .ACC_W(ACCW), .FB_SHIFT(SH)) u_dut (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .smp_i(smp),
      .bit_o(bit_o), .ovl_o(ovl_o));

   ns5_shaper #(.NUM_CH(1), .IN_W(INW), .ACC_W(INW), .FB_SHIFT(ZSH)) u_dut_ovl (
      .clk(clk), .rst_n(rst_n), .step_en(step_z), .smp_i(smp_z),
      .bit_o(bit_z), .ovl_o(ovl_z));

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // reference loop update for one channel, written from R3..R10
   task automatic model_step(input int ch, input longint raw, output bit b, output bit o);
      longint u, v;
      longint s [5];
      bit hit;
      u = raw;
      if (u > LIMV) u = LIMV;
      if (u < -LIMV) u = -LIMV;
      v = (mx[ch][4] >= 0) ? FBV : -FBV;
      s[0] = mx[ch][0] + ((u - v) >>> SH[0]);
      for (int k = 1; k < 5; k++) s[k] = mx[ch][k] + mx[ch][k-1] - (v >>> SH[k]);
      hit = 1'b0;
      for (int k = 0; k < 5; k++) if (s[k] >= MAXV || s[k] <= MINV) hit = 1'b1;
      for (int k = 0; k < 5; k++) mx[ch][k] = hit ? 0 : s[k];
      b = (mx[ch][4] >= 0);
      o = hit;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step_en = 1'b0;
      step_z = 1'b0;
      smp = '0;
      smp_z = '0;
      repeat (3) @(negedge clk);
      chk("R1 bits in reset", bit_o, 2'b11);
      rst_n = 1'b1;
      for (int c = 0; c < NCH; c++) for (int k = 0; k < 5; k++) mx[c][k] = 0;
      chk("R1 bits after reset", bit_o, 2'b11);
      chk("R1 pulse after reset", ovl_o, 0);
      chk("R1 second copy bit", bit_z, 1);
   endtask

   // called at a negedge; drives, waits one cycle, compares with the model
   task automatic apply(input bit en, input int a, input int b, input string tag);
      bit eb, eo;
      int va [NCH];
      va[0] = a;
      va[1] = b;
      step_en = en;
      smp = {INW'(b), INW'(a)};
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         if (en) begin
            model_step(c, longint'(va[c]), eb, eo);
         end else begin
            eb = (mx[c][4] >= 0);
            eo = 1'b0;
         end
         chk({tag, " bit"}, bit_o[c], eb);
         chk({tag, " pulse"}, ovl_o[c], eo);
      end
   endtask

   initial begin
      do_reset();

      // vector table: R4 R5 R6 R10 on each step, R2 on gated rows
      for (int i = 0; i < NVEC; i++)
         apply(VEC_EN[i], VEC_A[i], VEC_B[i], VEC_EN[i] ? "R4 R5 R6 R10 table" : "R2 table hold");

      // long run, channels fed differently: R9 and R7 via the model
      for (int i = 0; i < 600; i++) begin
         int t;
         int a;
         t = i % 120;
         a = (t < 60) ? (-1500 + t * 50) : (1500 - (t - 60) * 50);
         apply((i % 3) != 2, a, 333, "R9 R7 triangle");
      end

      // R3: over-range input must match the bound exactly
      do_reset();
      for (int i = 0; i < 200; i++) begin
         step_en = 1'b1;
         smp = {INW'(1024), INW'(2000)};
         @(negedge clk);
         chk("R3 positive clamp", bit_o[0], bit_o[1]);
      end
      do_reset();
      for (int i = 0; i < 200; i++) begin
         step_en = 1'b1;
         smp = {INW'(-1024), INW'(-2048)};
         @(negedge clk);
         chk("R3 negative clamp", bit_o[0], bit_o[1]);
      end
      step_en = 1'b0;

      // R7 R8: second copy saturates on its first update
      do_reset();
      step_z = 1'b1;
      smp_z = '0;
      @(negedge clk);
      chk("R7 clear pulse", ovl_z, 1);
      chk("R8 bit after clear", bit_z, 1);
      step_z = 1'b0;
      @(negedge clk);
      chk("R8 pulse lasts one cycle", ovl_z, 0);
      chk("R2 gated hold", bit_z, 1);
      step_z = 1'b1;
      smp_z = INW'(-1024);
      @(negedge clk);
      chk("R7 clear again", ovl_z, 1);
      chk("R8 bit again", bit_z, 1);
      step_z = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule